// File: doc/BRIEF.md
# Trigger-Indexed Pre-Execution Trace Cache

This block keeps a small set of helper-thread traces on chip. Each trace is a straight run of copied program instructions with no branches taken inside it. The trace is tagged with the program counter of its first instruction, which acts as the trigger. Traces come from an offline, profile-derived annotation stream through a load port, one instruction per beat. The hardware never builds traces itself.

A lookup port watches the program counters of the main thread. When a watched PC equals the tag of a valid entry, the block raises a one-cycle fork pulse naming the slot. It then presents the instructions of that trace to a fetch/rename consumer, one per cycle, under a valid/ready handshake. Every stored instruction is issued, branches included, and the thread stops after the last one, so a helper thread can never run away. Only one trace streams at a time. Triggers that arrive while a trace is streaming are dropped and counted. A flush input clears the whole store at once.

Top module: `preexec_trace_cache`

## Requirements
- R1: After reset no entry is valid, `out_valid` and `fork_valid` are 0, and `drop_count` is 0.
- R2: Load beats (`ld_valid`) write consecutive instructions of one trace, starting from the beat after the previous trace closed. A trace closes on a beat with `ld_last`=1, or on its `TRACE_LEN`-th beat (32 by default) whatever `ld_last` says. Its count is the number of beats, and it can be hit from the cycle after its closing beat.
- R3: A lookup (`mt_valid`=1) whose `mt_pc` equals the tag of a valid entry, made while no trace is streaming, gives `fork_valid`=1 for exactly one cycle after the next clock edge. In that same cycle `fork_slot` holds the entry's slot, `out_valid`=1, and `out_insn` holds the trace's first instruction.
- R4: A streaming trace presents its instructions in load order, each exactly once. `out_last`=1 marks the final one, and `out_valid` falls in the cycle after the final instruction is accepted.
- R5: While `out_valid`=1 and `out_ready`=0, the same instruction stays on `out_insn` and nothing is skipped or repeated.
- R6: A lookup that hits while a trace is streaming starts nothing, leaves the current stream unchanged, and adds 1 to `drop_count` (wrapping at 2^`DROP_W`).
- R7: The first beat of a load picks the slot as follows, in this order. If a valid entry already has the same tag, that slot is reused. Otherwise the lowest-numbered invalid slot is taken. If every slot is valid, the slot under a round-robin pointer is taken; the pointer starts at 0 and advances by one (wrapping) each time it is used.
- R8: `flush`=1 invalidates every entry, ends any streaming trace (`out_valid`=0 the next cycle), and abandons a partly loaded trace. It changes neither `drop_count` nor the round-robin pointer.
- R9: A lookup whose PC matches no valid tag, or a cycle without `mt_valid`, raises no fork and does not change `drop_count`.
- R10: The first beat of a load that takes the slot of the streaming trace ends that stream (`out_valid`=0 the next cycle). A lookup on a slot being taken in the same cycle is treated as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries and stop streaming |
| ld_valid | input | 1 | Load beat valid |
| ld_tag | input | PC_W | Trigger PC of the trace being loaded (used on its first beat) |
| ld_insn | input | INSN_W | Instruction word of this beat |
| ld_last | input | 1 | This beat closes the trace |
| mt_valid | input | 1 | Main-thread PC valid |
| mt_pc | input | PC_W | Main-thread PC to match |
| fork_valid | output | 1 | One-cycle fork request |
| fork_slot | output | $clog2(NUM_TRACES) | Slot of the forked trace |
| out_valid | output | 1 | Trace instruction valid |
| out_ready | input | 1 | Consumer accepts the instruction |
| out_insn | output | INSN_W | Trace instruction |
| out_last | output | 1 | Final instruction of the trace |
| drop_count | output | DROP_W | Number of dropped triggers |

## Verification
The checker assumes that load beats belong to one trace at a time, that `ld_tag` matters only on a trace's first beat, and that `out_ready` may change in any cycle. Its hold-stable property is therefore conditioned on a cycle with neither a flush nor a load beat, because those are the only inputs that may legally end a stream. The stimulus drives all inputs half a cycle away from the sampling edge. It closes a trace by count only at exactly `TRACE_LEN` beats, and it makes a load and a lookup collide on one slot only in the R10 case, so every other lookup sees settled tags.

// File: rtl/pxc_pkg.sv
package pxc_pkg;

   typedef enum logic [1:0] {
      ALLOC_MATCH = 2'd0,
      ALLOC_FREE  = 2'd1,
      ALLOC_EVICT = 2'd2
   } alloc_kind_e;

endpackage

// File: rtl/pxc_tag_match.sv
module pxc_tag_match #(
   parameter int ENTRIES = 16,
   parameter int KEY_W   = 32
) (
   input  logic [ENTRIES-1:0]            live,
   input  logic [ENTRIES-1:0][KEY_W-1:0] tags,
   input  logic [KEY_W-1:0]              key,
   output logic [ENTRIES-1:0]            hits
);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign hits[e] = live[e] && (tags[e] == key);
   end

endmodule

// File: rtl/pxc_lowest.sv
module pxc_lowest #(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] vec,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);

   always_comb begin
      any = |vec;
      idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/pxc_seq.sv
module pxc_seq #(
   parameter int ENTRIES = 16,
   parameter int DEPTH   = 32,
   parameter int DROP_W  = 16,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int POS_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              hit,
   input  logic [IDX_W-1:0]  hit_slot,
   input  logic              abort,
   input  logic              ready,
   input  logic [CNT_W-1:0]  cur_cnt,
   output logic              busy,
   output logic [IDX_W-1:0]  slot,
   output logic [POS_W-1:0]  pos,
   output logic              last,
   output logic              fork_pulse,
   output logic [DROP_W-1:0] drops
);

   assign last = (CNT_W'(pos) + CNT_W'(1)) == cur_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         slot       <= '0;
         pos        <= '0;
         fork_pulse <= 1'b0;
         drops      <= '0;
      end else begin
         fork_pulse <= 1'b0;
         if (flush) begin
            busy <= 1'b0;
         end else begin
            if (hit && busy) drops <= drops + DROP_W'(1);
            if (!busy) begin
               if (hit) begin
                  busy       <= 1'b1;
                  slot       <= hit_slot;
                  pos        <= '0;
                  fork_pulse <= 1'b1;
               end
            end else if (abort) begin
               busy <= 1'b0;
            end else if (ready) begin
               if (last) busy <= 1'b0;
               else      pos  <= pos + POS_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/preexec_trace_cache.sv
module preexec_trace_cache
   import pxc_pkg::*;
#(
   parameter int NUM_TRACES = 16,
   parameter int TRACE_LEN  = 32,
   parameter int PC_W       = 32,
   parameter int INSN_W     = 32,
   parameter int DROP_W     = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic                          ld_valid,
   input  logic [PC_W-1:0]               ld_tag,
   input  logic [INSN_W-1:0]             ld_insn,
   input  logic                          ld_last,
   input  logic                          mt_valid,
   input  logic [PC_W-1:0]               mt_pc,
   output logic                          fork_valid,
   output logic [$clog2(NUM_TRACES)-1:0] fork_slot,
   output logic                          out_valid,
   input  logic                          out_ready,
   output logic [INSN_W-1:0]             out_insn,
   output logic                          out_last,
   output logic [DROP_W-1:0]             drop_count
);

   localparam int SLOT_W    = $clog2(NUM_TRACES);
   localparam int POS_W     = $clog2(TRACE_LEN);
   localparam int CNT_W     = $clog2(TRACE_LEN + 1);
   localparam int MEM_DEPTH = NUM_TRACES * TRACE_LEN;
   localparam int MEM_AW    = $clog2(MEM_DEPTH);
   localparam bit LEN_POW2  = (TRACE_LEN & (TRACE_LEN - 1)) == 0;

   if (NUM_TRACES < 2) begin : g_bad_entries
      $error("NUM_TRACES must be at least 2");
   end
   if (TRACE_LEN < 2) begin : g_bad_len
      $error("TRACE_LEN must be at least 2");
   end
   if (PC_W < 1 || INSN_W < 1 || DROP_W < 1) begin : g_bad_width
      $error("widths must be positive");
   end

   // entry state
   logic [NUM_TRACES-1:0]             ent_valid;
   logic [NUM_TRACES-1:0][PC_W-1:0]   ent_tag;
   logic [NUM_TRACES-1:0][CNT_W-1:0]  ent_cnt;
   logic [INSN_W-1:0]                 trace_mem [MEM_DEPTH];

   // load state
   logic              ld_open;
   logic [SLOT_W-1:0] ld_slot;
   logic [POS_W-1:0]  ld_pos;
   logic [SLOT_W-1:0] rr_ptr;

   // allocation
   logic [NUM_TRACES-1:0] same_tag_vec;
   logic                  same_any, free_any;
   logic [SLOT_W-1:0]     same_idx, free_idx;
   logic [SLOT_W-1:0]     alloc_slot;
   alloc_kind_e           alloc_kind;
   logic                  beat, ld_first, wr_end;
   logic [SLOT_W-1:0]     wr_slot;
   logic [POS_W-1:0]      wr_pos;
   logic [NUM_TRACES-1:0] alloc_vec;
   logic [MEM_AW-1:0]     wr_addr, rd_addr;

   // lookup and sequencer
   logic [NUM_TRACES-1:0] pc_hit_vec;
   logic                  pc_any;
   logic [SLOT_W-1:0]     pc_idx;
   logic                  lookup_hit;
   logic                  seq_busy, seq_last, seq_abort;
   logic [SLOT_W-1:0]     seq_slot;
   logic [POS_W-1:0]      seq_pos;

   assign beat     = ld_valid && !flush;
   assign ld_first = beat && !ld_open;

   pxc_tag_match #(.ENTRIES(NUM_TRACES), .KEY_W(PC_W)) u_ld_match (
      .live(ent_valid), .tags(ent_tag), .key(ld_tag), .hits(same_tag_vec)
   );

   pxc_lowest #(.ENTRIES(NUM_TRACES)) u_same_enc (
      .vec(same_tag_vec), .any(same_any), .idx(same_idx)
   );

   pxc_lowest #(.ENTRIES(NUM_TRACES)) u_free_enc (
      .vec(~ent_valid), .any(free_any), .idx(free_idx)
   );

   always_comb begin
      if (same_any) begin
         alloc_kind = ALLOC_MATCH;
         alloc_slot = same_idx;
      end else if (free_any) begin
         alloc_kind = ALLOC_FREE;
         alloc_slot = free_idx;
      end else begin
         alloc_kind = ALLOC_EVICT;
         alloc_slot = rr_ptr;
      end
   end

   always_comb begin
      alloc_vec = '0;
      if (ld_first) alloc_vec[alloc_slot] = 1'b1;
   end

   assign wr_slot = ld_open ? ld_slot : alloc_slot;
   assign wr_pos  = ld_open ? ld_pos  : '0;
   assign wr_end  = ld_last || (wr_pos == POS_W'(TRACE_LEN - 1));

   if (LEN_POW2) begin : g_addr_cat
      assign wr_addr = {wr_slot, wr_pos};
      assign rd_addr = {seq_slot, seq_pos};
   end else begin : g_addr_mul
      assign wr_addr = MEM_AW'(wr_slot) * MEM_AW'(TRACE_LEN) + MEM_AW'(wr_pos);
      assign rd_addr = MEM_AW'(seq_slot) * MEM_AW'(TRACE_LEN) + MEM_AW'(seq_pos);
   end

   always_ff @(posedge clk) begin
      if (beat) trace_mem[wr_addr] <= ld_insn;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_valid <= '0;
         ent_tag   <= '0;
         ent_cnt   <= '0;
         ld_open   <= 1'b0;
         ld_slot   <= '0;
         ld_pos    <= '0;
         rr_ptr    <= '0;
      end else if (flush) begin
         ent_valid <= '0;
         ld_open   <= 1'b0;
      end else if (beat) begin
         if (ld_first) begin
            ent_valid[alloc_slot] <= 1'b0;
            ent_tag[alloc_slot]   <= ld_tag;
            if (alloc_kind == ALLOC_EVICT) begin
               rr_ptr <= (rr_ptr == SLOT_W'(NUM_TRACES - 1)) ? '0 : rr_ptr + SLOT_W'(1);
            end
         end
         if (wr_end) begin
            ent_valid[wr_slot] <= 1'b1;
            ent_cnt[wr_slot]   <= CNT_W'(wr_pos) + CNT_W'(1);
            ld_open            <= 1'b0;
         end else begin
            ld_open <= 1'b1;
            ld_slot <= wr_slot;
            ld_pos  <= wr_pos + POS_W'(1);
         end
      end
   end

   // lookup ignores a slot whose tag is being replaced in this cycle
   pxc_tag_match #(.ENTRIES(NUM_TRACES), .KEY_W(PC_W)) u_pc_match (
      .live(ent_valid & ~alloc_vec), .tags(ent_tag), .key(mt_pc), .hits(pc_hit_vec)
   );

   pxc_lowest #(.ENTRIES(NUM_TRACES)) u_pc_enc (
      .vec(pc_hit_vec), .any(pc_any), .idx(pc_idx)
   );

   assign lookup_hit = mt_valid && pc_any && !flush;
   assign seq_abort  = ld_first && (alloc_slot == seq_slot);

   pxc_seq #(.ENTRIES(NUM_TRACES), .DEPTH(TRACE_LEN), .DROP_W(DROP_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .hit        (lookup_hit),
      .hit_slot   (pc_idx),
      .abort      (seq_abort),
      .ready      (out_ready),
      .cur_cnt    (ent_cnt[seq_slot]),
      .busy       (seq_busy),
      .slot       (seq_slot),
      .pos        (seq_pos),
      .last       (seq_last),
      .fork_pulse (fork_valid),
      .drops      (drop_count)
   );

   assign fork_slot = seq_slot;
   assign out_valid = seq_busy;
   assign out_insn  = trace_mem[rd_addr];
   assign out_last  = seq_busy && seq_last;

endmodule

// File: rtl/pxc_checker.sv
module pxc_checker #(
   parameter int INSN_W = 32,
   parameter int DROP_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush,
   input logic              ld_valid,
   input logic              mt_valid,
   input logic              lookup_hit,
   input logic              fork_valid,
   input logic              out_valid,
   input logic              out_ready,
   input logic [INSN_W-1:0] out_insn,
   input logic              out_last,
   input logic [DROP_W-1:0] drop_count
);

   AST_FORK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fork_valid |=> !fork_valid) else $error("fork longer than one cycle"); // R3

   AST_FORK_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      fork_valid |-> out_valid) else $error("fork without stream"); // R3

   AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> !out_valid) else $error("stream ran past last"); // R4

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !flush && !ld_valid) |=> (out_valid && $stable(out_insn)))
      else $error("stalled instruction changed"); // R5

   AST_DROP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && lookup_hit) |=> (drop_count == $past(drop_count) + DROP_W'(1)))
      else $error("dropped trigger not counted"); // R6

   AST_FLUSH_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!out_valid && !fork_valid)) else $error("flush did not stop stream"); // R8

   AST_NO_SPURIOUS_FORK: assert property (@(posedge clk) disable iff (!rst_n)
      !mt_valid |=> !fork_valid) else $error("fork without lookup"); // R9

endmodule

bind preexec_trace_cache pxc_checker #(.INSN_W(INSN_W), .DROP_W(DROP_W)) i_pxc_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush      (flush),
   .ld_valid   (ld_valid),
   .mt_valid   (mt_valid),
   .lookup_hit (lookup_hit),
   .fork_valid (fork_valid),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_insn   (out_insn),
   .out_last   (out_last),
   .drop_count (drop_count)
);

// File: tb/test_preexec_trace_cache.sv
module test_preexec_trace_cache;

   localparam int N = 16;
   localparam int L = 32;

   logic        clk = 1'b0;
   logic        rst_n, flush, ld_valid, ld_last, mt_valid, out_ready;
   logic [31:0] ld_tag, ld_insn, mt_pc;
   logic        fork_valid, out_valid, out_last;
   logic [3:0]  fork_slot;
   logic [31:0] out_insn;
   logic [15:0] drop_count;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   preexec_trace_cache i_preexec_trace_cache (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_insn(ld_insn), .ld_last(ld_last),
      .mt_valid(mt_valid), .mt_pc(mt_pc),
      .fork_valid(fork_valid), .fork_slot(fork_slot),
      .out_valid(out_valid), .out_ready(out_ready), .out_insn(out_insn),
      .out_last(out_last), .drop_count(drop_count)
   );

   // ---------------- behavioural reference model ----------------
   bit          m_valid [N];
   logic [31:0] m_tag   [N];
   int          m_cnt   [N];
   logic [31:0] m_mem   [N][L];
   bit          m_ldopen;
   int          m_ldslot, m_ldpos, m_rr;
   bit          m_busy, m_fork;
   int          m_slot, m_pos;
   int          m_drop;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_valid[i]) m_valid[i] = 0;
         m_ldopen = 0; m_rr = 0; m_busy = 0; m_fork = 0;
         m_slot = 0; m_pos = 0; m_drop = 0;
      end else if (flush) begin
         foreach (m_valid[i]) m_valid[i] = 0;
         m_ldopen = 0; m_busy = 0; m_fork = 0;
      end else begin
         bit first, evict, hit, old_busy;
         int aslot, hslot, ws, wp;
         first = ld_valid && !m_ldopen;
         aslot = -1; evict = 0;
         if (first) begin
            for (int i = 0; i < N; i++)
               if (aslot < 0 && m_valid[i] && m_tag[i] == ld_tag) aslot = i;
            if (aslot < 0)
               for (int i = 0; i < N; i++)
                  if (aslot < 0 && !m_valid[i]) aslot = i;
            if (aslot < 0) begin aslot = m_rr; evict = 1; end
         end
         hslot = -1;
         if (mt_valid)
            for (int i = 0; i < N; i++)
               if (hslot < 0 && m_valid[i] && m_tag[i] == mt_pc && i != aslot) hslot = i;
         hit = (hslot >= 0);
         old_busy = m_busy;
         m_fork = 0;
         if (hit && old_busy) m_drop = (m_drop + 1) % 65536;
         if (!old_busy) begin
            if (hit) begin m_busy = 1; m_slot = hslot; m_pos = 0; m_fork = 1; end
         end else if (first && aslot == m_slot) begin
            m_busy = 0;
         end else if (out_ready) begin
            if (m_pos == m_cnt[m_slot] - 1) m_busy = 0;
            else m_pos++;
         end
         if (ld_valid) begin
            ws = first ? aslot : m_ldslot;
            wp = first ? 0 : m_ldpos;
            m_mem[ws][wp] = ld_insn;
            if (first) begin
               m_valid[ws] = 0;
               m_tag[ws] = ld_tag;
               if (evict) m_rr = (m_rr + 1) % N;
            end
            if (ld_last || wp == L - 1) begin
               m_valid[ws] = 1; m_cnt[ws] = wp + 1; m_ldopen = 0;
            end else begin
               m_ldopen = 1; m_ldslot = ws; m_ldpos = wp + 1;
            end
         end
      end
   end

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R3 fork_valid vs model", 64'(fork_valid), 64'(m_fork));
         if (m_fork) chk("R3 fork_slot vs model", 64'(fork_slot), 64'(m_slot));
         chk("R4 out_valid vs model", 64'(out_valid), 64'(m_busy));
         if (m_busy) begin
            chk("R4 out_insn vs model", 64'(out_insn), 64'(m_mem[m_slot][m_pos]));
            chk("R4 out_last vs model", 64'(out_last), 64'(m_pos == m_cnt[m_slot] - 1));
         end
         chk("R6 drop_count vs model", 64'(drop_count), 64'(m_drop));
      end
   end

   function automatic logic [31:0] mk(input logic [31:0] t, input int i);
      return {t[23:0], 8'(i)};
   endfunction

   task automatic load(input logic [31:0] tag, input int n, input bit close);
      for (int i = 0; i < n; i++) begin
         ld_valid = 1; ld_tag = tag; ld_insn = mk(tag, i);
         ld_last = close && (i == n - 1);
         @(negedge clk);
      end
      ld_valid = 0; ld_last = 0;
   endtask

   task automatic lookup(input logic [31:0] pc);
      mt_valid = 1; mt_pc = pc;
      @(negedge clk);
      mt_valid = 0;
   endtask

   task automatic drain(output int n);
      n = 0;
      for (int g = 0; g < 200 && out_valid; g++) begin
         if (out_ready) n++;
         @(negedge clk);
      end
   endtask

   bit done = 0;

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int n;
      logic [31:0] held;
      logic [15:0] d0;
      rst_n = 0; flush = 0; ld_valid = 0; ld_last = 0; mt_valid = 0; out_ready = 1;
      ld_tag = 0; ld_insn = 0; mt_pc = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 out_valid after reset", 64'(out_valid), 0);
      chk("R1 fork_valid after reset", 64'(fork_valid), 0);
      chk("R1 drop_count after reset", 64'(drop_count), 0);
      lookup(32'h100);
      chk("R1 no hit on empty store", 64'(fork_valid), 0);

      load(32'h100, 3, 1);
      load(32'h200, 5, 1);
      lookup(32'h200);
      chk("R3 fork_valid on hit", 64'(fork_valid), 1);
      chk("R7 fork_slot lowest free", 64'(fork_slot), 1);
      chk("R2 first instruction", 64'(out_insn), 64'(mk(32'h200, 0)));
      drain(n);
      chk("R4 streamed count", 64'(n), 5);

      out_ready = 0;
      lookup(32'h100);
      held = out_insn;
      repeat (3) begin
         @(negedge clk);
         chk("R5 stall holds valid", 64'(out_valid), 1);
         chk("R5 stall holds insn", 64'(out_insn), 64'(held));
      end
      out_ready = 1;
      drain(n);
      chk("R5 no loss after stall", 64'(n), 3);

      lookup(32'h200);
      lookup(32'h100);
      chk("R6 drop counted", 64'(drop_count), 1);
      chk("R6 stream unaffected", 64'(out_valid), 1);
      drain(n);

      d0 = drop_count;
      lookup(32'h999);
      chk("R9 miss no fork", 64'(fork_valid), 0);
      chk("R9 miss no drop", 64'(drop_count), 64'(d0));

      load(32'h100, 2, 1);
      lookup(32'h100);
      chk("R7 same tag reuses slot", 64'(fork_slot), 0);
      drain(n);
      chk("R7 overwritten length", 64'(n), 2);

      load(32'h300, L, 0);
      lookup(32'h300);
      chk("R2 long trace slot", 64'(fork_slot), 2);
      drain(n);
      chk("R2 capped length", 64'(n), L);

      for (int k = 0; k < 13; k++) load(32'h400 + 32'(k), 1, 1);
      load(32'h500, 1, 1);
      lookup(32'h500);
      chk("R7 round robin first victim", 64'(fork_slot), 0);
      drain(n);
      load(32'h501, 1, 1);
      lookup(32'h501);
      chk("R7 round robin second victim", 64'(fork_slot), 1);
      drain(n);
      lookup(32'h200);
      chk("R7 evicted tag misses", 64'(fork_valid), 0);

      out_ready = 0;
      lookup(32'h300);
      chk("R10 stream running", 64'(out_valid), 1);
      ld_valid = 1; ld_tag = 32'h300; ld_insn = mk(32'h300, 0); ld_last = 0;
      @(negedge clk);
      chk("R10 reload aborts stream", 64'(out_valid), 0);
      ld_insn = mk(32'h300, 1); ld_last = 1;
      @(negedge clk);
      ld_valid = 0; ld_last = 0;
      out_ready = 1;

      d0 = drop_count;
      ld_valid = 1; ld_tag = 32'h401; ld_insn = 32'hABCD; ld_last = 1;
      mt_valid = 1; mt_pc = 32'h401;
      @(negedge clk);
      ld_valid = 0; ld_last = 0; mt_valid = 0;
      chk("R10 lookup on reallocated slot misses", 64'(fork_valid), 0);
      chk("R10 no drop on masked hit", 64'(drop_count), 64'(d0));
      lookup(32'h401);
      chk("R10 reloaded entry hits", 64'(fork_slot), 4);
      chk("R10 reloaded data", 64'(out_insn), 64'h0000ABCD);
      drain(n);

      out_ready = 0;
      lookup(32'h300);
      d0 = drop_count;
      flush = 1;
      @(negedge clk);
      flush = 0;
      chk("R8 flush stops stream", 64'(out_valid), 0);
      chk("R8 flush keeps drops", 64'(drop_count), 64'(d0));
      lookup(32'h300);
      chk("R8 flushed entry misses", 64'(fork_valid), 0);
      out_ready = 1;
      load(32'h600, 2, 1);
      lookup(32'h600);
      chk("R8 store empty after flush", 64'(fork_slot), 0);
      drain(n);
      chk("R4 post flush count", 64'(n), 2);

      repeat (2) @(negedge clk);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule